// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block orders the start-up and shutdown of a multi-phase buck regulator's digital side. After reset it leaves every PWM output undriven, so that external strap resistors can be read. Once the configuration-collection phase reports completion, the outputs park at a mid-level "diode mode" state. When enable is requested and the external gate driver is not holding the line off, the block raises its driver-enable output. It then walks an internal reference code from zero toward its target, one LSB at a time.

The target is the boot code when that code is non-zero. Otherwise the rail holds at zero until a VID command arrives. A VID command that arrives during the ramp redirects the walk from wherever it stands. The walk speed is set by a divider input: one step per N clocks. Each phase leaves the mid state on its own first PWM pulse and afterwards follows the raw pulse as plain high/low drive. Dropping enable parks every phase at mid again and clears the reference code.

Top module: `softstart_ramp_seq`

## Requirements
- R1: From reset until `cfgDone` is seen high, every phase field of `pwmState` is high-Z (2'b11), `drvEnOut` is 0 and `dacCode` is 0.
- R2: After configuration is collected and while `enReq` is low, every phase field is mid (2'b10), `drvEnOut` is 0 and `dacCode` is 0.
- R3: After `enReq` rises (with `drvReady` high), the phases are at mid for one full cycle with `drvEnOut` low. `drvEnOut` then goes high and stays high while `enReq` stays high.
- R4: While `drvReady` is low, an enable request does not start the sequence: `drvEnOut` and `dacCode` stay 0 until `drvReady` returns high.
- R5: While running, `dacCode` moves by exactly one LSB every N clocks toward the target, where N is `slewDiv` and a `slewDiv` of 0 acts as 1. Starting from the first cycle with `drvEnOut` high, a non-zero boot code T is reached after T*N cycles.
- R6: With a boot code of 0, `dacCode` stays 0 until a `vidValid` strobe while running. It then ramps to `vidCode`, which is reached T*N+1 cycles after the strobe.
- R7: `rampDone` is high for exactly the cycle in which `dacCode` first shows a newly reached target. A command whose target equals the present code gives no pulse.
- R8: A `vidValid` strobe during a ramp replaces the target without clearing `dacCode`. The ramp continues from the present code, downward if the new target is lower. A step that lands on the old target while a new target is being loaded gives no `rampDone`.
- R9: While running, each phase stays mid until its own `pwmRaw` bit is first seen high. From that point it shows high (2'b01) when its raw bit is 1 and low (2'b00) when it is 0. The other phases are unaffected.
- R10: When `enReq` falls, all phases are mid and `drvEnOut` is 0 in the next cycle, and `dacCode` is 0 one cycle later. `pwmRaw` pulses while disabled leave the phases at mid.
- R11: A `vidValid` strobe while not running is ignored: it sets no target for the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enReq | input | 1 | Enable request for the rail |
| cfgDone | input | 1 | Strap/configuration collection finished |
| drvReady | input | 1 | Gate driver released the enable line (0 = driver holds start-up off) |
| bootCode | input | DW (8) | Boot reference code; 0 means wait for a VID command |
| vidCode | input | DW (8) | Commanded reference code |
| vidValid | input | 1 | One-cycle strobe that loads `vidCode` as the target |
| slewDiv | input | DIVW (8) | Clocks per DAC step (0 treated as 1) |
| pwmRaw | input | NPH (2) | Raw PWM pulses from the modulator, one per phase |
| dacCode | output | DW (8) | Internal reference code |
| rampDone | output | 1 | One-cycle pulse when the target is reached |
| drvEnOut | output | 1 | Driver enable |
| pwmState | output | 2*NPH (4) | Per-phase drive state: 00 low, 01 high, 10 mid, 11 high-Z; phase i in bits [2i+1:2i] |

## Verification
The critical coincidence is a VID redirect strobe that falls in the same cycle as the divider's terminal count, when that step lands exactly on the old target. The bench provokes it with a divider of 1 and a small boot code. It applies the new command in the cycle where the code sits one LSB short of the boot value. It then judges that no completion pulse appears on the boot value, and that exactly one pulse appears when the code reaches the new target. A second overlap occurs when a phase's first pulse and a disable arrive together. The bench checks that disabling returns every phase to mid no matter what the release latches hold.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  // per-phase drive encoding
  typedef enum logic [1:0] {
    DRV_LOW  = 2'b00,
    DRV_HIGH = 2'b01,
    DRV_MID  = 2'b10,
    DRV_HIZ  = 2'b11
  } drv_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic hiz;       // configuration window: pins undriven
    logic loadBoot;  // arm cycle: capture boot target
    logic run;       // ramp and phase release active
  } ssr_strb_t;

endpackage

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enReq,
  input  logic      cfgDone,
  input  logic      drvReady,
  output ssr_strb_t strb,
  output logic      drvEnOut
);

  typedef enum logic [1:0] {
    S_CFG  = 2'd0,
    S_IDLE = 2'd1,
    S_ARM  = 2'd2,
    S_RUN  = 2'd3
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_CFG:  if (cfgDone) stateNext = S_IDLE;
      S_IDLE: if (enReq && drvReady) stateNext = S_ARM;
      S_ARM:  stateNext = enReq ? S_RUN : S_IDLE;
      S_RUN:  if (!enReq) stateNext = S_IDLE;
      default: stateNext = S_CFG;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_CFG;
    else       state <= stateNext;
  end

  always_comb begin
    strb.hiz      = (state == S_CFG);
    strb.loadBoot = (state == S_ARM);
    strb.run      = (state == S_RUN);
  end

  assign drvEnOut = (state == S_RUN);

  // R4: driver enable only rises after an idle cycle that saw the driver released
  p_holdoff_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drvEnOut) |-> ($past(drvReady, 2) && $past(enReq)));

  // R3: a rise of driver enable is always preceded by the arm cycle
  p_arm_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drvEnOut) |-> $past(strb.loadBoot));

endmodule

// File: rtl/ssr_datapath.sv
module ssr_datapath
  import ssr_pkg::*;
#(
  parameter int NPH  = 2,
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ssr_strb_t        strb,
  input  logic [DW-1:0]    bootCode,
  input  logic [DW-1:0]    vidCode,
  input  logic             vidValid,
  input  logic [DIVW-1:0]  slewDiv,
  input  logic [NPH-1:0]   pwmRaw,
  output logic [DW-1:0]    dacCode,
  output logic             rampDone,
  output logic [2*NPH-1:0] pwmState
);

  localparam logic [DIVW-1:0] DIV_ONE = DIVW'(1);

  logic [DW-1:0]   tgtCode, tgtNext, dacStep;
  logic            tgtValid, tgtValidNext;
  logic [DIVW-1:0] divCnt, divEff;
  logic            needStep, divTerm, goUp;

  // target selection: boot on arm, VID while running, cleared otherwise
  always_comb begin
    tgtNext      = tgtCode;
    tgtValidNext = tgtValid;
    if (strb.loadBoot) begin
      tgtNext      = bootCode;
      tgtValidNext = (bootCode != '0);
    end else if (strb.run && vidValid) begin
      tgtNext      = vidCode;
      tgtValidNext = 1'b1;
    end else if (!strb.run) begin
      tgtNext      = '0;
      tgtValidNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtCode  <= '0;
      tgtValid <= 1'b0;
    end else begin
      tgtCode  <= tgtNext;
      tgtValid <= tgtValidNext;
    end
  end

  // slew divider and ramp counter
  assign divEff   = (slewDiv == '0) ? DIV_ONE : slewDiv;
  assign divTerm  = (divCnt >= divEff - DIV_ONE);
  assign needStep = strb.run && tgtValid && (dacCode != tgtCode);
  assign goUp     = (tgtCode > dacCode);
  assign dacStep  = goUp ? dacCode + DW'(1) : dacCode - DW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode  <= '0;
      divCnt   <= '0;
      rampDone <= 1'b0;
    end else if (!strb.run) begin
      dacCode  <= '0;
      divCnt   <= '0;
      rampDone <= 1'b0;
    end else if (needStep) begin
      if (divTerm) begin
        divCnt   <= '0;
        dacCode  <= dacStep;
        rampDone <= (dacStep == tgtNext);
      end else begin
        divCnt   <= divCnt + DIVW'(1);
        rampDone <= 1'b0;
      end
    end else begin
      divCnt   <= '0;
      rampDone <= 1'b0;
    end
  end

  // per-phase release from mid state
  logic [NPH-1:0] released;

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    logic driveNow;
    assign driveNow = strb.run && (released[i] || pwmRaw[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          released[i] <= 1'b0;
      else if (!strb.run) released[i] <= 1'b0;
      else if (pwmRaw[i]) released[i] <= 1'b1;
    end

    always_comb begin
      if (strb.hiz)     pwmState[2*i +: 2] = DRV_HIZ;
      else if (driveNow) pwmState[2*i +: 2] = pwmRaw[i] ? DRV_HIGH : DRV_LOW;
      else              pwmState[2*i +: 2] = DRV_MID;
    end

    // R9/R10: a phase never drives high or low while the sequencer is not running
    p_no_drive_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
      !strb.run |-> pwmState[2*i+1]);
  end

  // R5: successive codes differ by at most one LSB while running
  p_one_lsb_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |=> (dacCode == $past(dacCode) ||
                  dacCode == $past(dacCode) + DW'(1) ||
                  dacCode == $past(dacCode) - DW'(1)));

  // R7: completion pulse only when the code sits on the target
  p_done_on_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    rampDone |-> (dacCode == tgtCode && tgtValid));

  // R2: code returns to zero one cycle after leaving the running state
  p_zero_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (dacCode == '0));

endmodule

// File: rtl/softstart_ramp_seq.sv
module softstart_ramp_seq
  import ssr_pkg::*;
#(
  parameter int NPH  = 2,
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enReq,
  input  logic             cfgDone,
  input  logic             drvReady,
  input  logic [DW-1:0]    bootCode,
  input  logic [DW-1:0]    vidCode,
  input  logic             vidValid,
  input  logic [DIVW-1:0]  slewDiv,
  input  logic [NPH-1:0]   pwmRaw,
  output logic [DW-1:0]    dacCode,
  output logic             rampDone,
  output logic             drvEnOut,
  output logic [2*NPH-1:0] pwmState
);

  localparam logic [2*NPH-1:0] ALL_MID = {NPH{DRV_MID}};

  ssr_strb_t strb;

  ssr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enReq    (enReq),
    .cfgDone  (cfgDone),
    .drvReady (drvReady),
    .strb     (strb),
    .drvEnOut (drvEnOut)
  );

  ssr_datapath #(.NPH(NPH), .DW(DW), .DIVW(DIVW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bootCode (bootCode),
    .vidCode  (vidCode),
    .vidValid (vidValid),
    .slewDiv  (slewDiv),
    .pwmRaw   (pwmRaw),
    .dacCode  (dacCode),
    .rampDone (rampDone),
    .pwmState (pwmState)
  );

  // R3: all phases parked at mid in the cycle before driver enable rises
  p_mid_before_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drvEnOut) |-> ($past(pwmState) == ALL_MID));

endmodule

// File: tb/softstart_ramp_seq_tb.sv
module softstart_ramp_seq_tb;

  localparam int NPH = 2;
  localparam int DW = 8;
  localparam int DIVW = 8;
  localparam logic [3:0] ALL_HIZ = 4'b1111;
  localparam logic [3:0] ALL_MID = 4'b1010;

  // ramp vectors: {bootCode, slewDiv}
  localparam int NVEC = 4;
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd5,  8'd3},
    {8'd1,  8'd1},
    {8'd12, 8'd0},
    {8'd9,  8'd4}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enReq = 1'b0, cfgDone = 1'b0, drvReady = 1'b1, vidValid = 1'b0;
  logic [DW-1:0] bootCode = '0, vidCode = '0;
  logic [DIVW-1:0] slewDiv = 8'd1;
  logic [NPH-1:0] pwmRaw = '0;
  logic [DW-1:0] dacCode;
  logic rampDone, drvEnOut;
  logic [2*NPH-1:0] pwmState;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  softstart_ramp_seq #(.NPH(NPH), .DW(DW), .DIVW(DIVW)) u_dut (
    .clk(clk), .rstN(rstN), .enReq(enReq), .cfgDone(cfgDone),
    .drvReady(drvReady), .bootCode(bootCode), .vidCode(vidCode),
    .vidValid(vidValid), .slewDiv(slewDiv), .pwmRaw(pwmRaw),
    .dacCode(dacCode), .rampDone(rampDone), .drvEnOut(drvEnOut),
    .pwmState(pwmState)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bring the rail to idle, then enable and wait for driver enable
  task automatic start_run(input logic [DW-1:0] boot, input logic [DIVW-1:0] div);
    enReq = 1'b0;
    tick(); tick();
    bootCode = boot;
    slewDiv = div;
    enReq = 1'b1;
    for (int k = 0; k < 10 && !drvEnOut; k++) tick();
  endtask

  // count cycles until rampDone, tracking the largest single jump
  task automatic wait_done(input int limit, output int cyc, output int jump, output int lowest);
    int prev;
    cyc = 0; jump = 0; prev = dacCode; lowest = dacCode;
    while (!rampDone && cyc < limit) begin
      tick();
      cyc++;
      if ((dacCode > prev ? dacCode - prev : prev - dacCode) > jump)
        jump = (dacCode > prev) ? dacCode - prev : prev - dacCode;
      if (dacCode < lowest) lowest = dacCode;
      prev = dacCode;
    end
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int cyc, jump, lowest, exp, n;
    bit seen;

    // R1: reset state and configuration window
    #1;
    check(pwmState == ALL_HIZ, "R1 hiz in reset", pwmState, ALL_HIZ);
    tick(); tick();
    rstN = 1'b1;
    enReq = 1'b1;
    tick(); tick(); tick();
    check(pwmState == ALL_HIZ, "R1 hiz before cfgDone", pwmState, ALL_HIZ);
    check(drvEnOut == 1'b0, "R1 driver off before cfgDone", drvEnOut, 0);
    check(dacCode == '0, "R1 code zero before cfgDone", dacCode, 0);

    // R2: disabled after configuration
    enReq = 1'b0;
    cfgDone = 1'b1;
    tick(); tick();
    check(pwmState == ALL_MID, "R2 mid when disabled", pwmState, ALL_MID);
    check(drvEnOut == 1'b0, "R2 driver off when disabled", drvEnOut, 0);

    // R11: VID strobe while idle is ignored
    vidCode = 8'd9;
    vidValid = 1'b1;
    tick();
    vidValid = 1'b0;
    start_run(8'd0, 8'd1);
    for (int k = 0; k < 30; k++) tick();
    check(dacCode == '0, "R11 idle VID ignored", dacCode, 0);

    // R3: mid for one cycle, then driver enable
    enReq = 1'b0;
    tick(); tick();
    bootCode = 8'd3;
    enReq = 1'b1;
    tick();
    check(drvEnOut == 1'b0, "R3 driver off in arm cycle", drvEnOut, 0);
    check(pwmState == ALL_MID, "R3 mid in arm cycle", pwmState, ALL_MID);
    tick();
    check(drvEnOut == 1'b1, "R3 driver on after arm", drvEnOut, 1);
    check(pwmState == ALL_MID, "R3 mid at driver enable", pwmState, ALL_MID);

    // R5/R7: table of ramp vectors
    for (int v = 0; v < NVEC; v++) begin
      start_run(VEC[v][15:8], VEC[v][7:0]);
      n = (VEC[v][7:0] == 0) ? 1 : int'(VEC[v][7:0]);
      exp = int'(VEC[v][15:8]) * n;
      wait_done(5000, cyc, jump, lowest);
      check(cyc == exp, "R5 ramp time", cyc, exp);
      check(dacCode == VEC[v][15:8], "R5 final code", dacCode, VEC[v][15:8]);
      check(jump <= 1, "R5 one LSB per step", jump, 1);
      tick();
      check(rampDone == 1'b0, "R7 single-cycle done", rampDone, 0);
    end

    // R4: driver holding enable line off
    enReq = 1'b0;
    tick(); tick();
    drvReady = 1'b0;
    bootCode = 8'd4;
    enReq = 1'b1;
    for (int k = 0; k < 12; k++) tick();
    check(drvEnOut == 1'b0, "R4 held off", drvEnOut, 0);
    check(dacCode == '0, "R4 code held", dacCode, 0);
    drvReady = 1'b1;
    tick(); tick(); tick();
    check(drvEnOut == 1'b1, "R4 start after release", drvEnOut, 1);

    // R6: zero boot waits for VID
    start_run(8'd0, 8'd1);
    for (int k = 0; k < 20; k++) tick();
    check(dacCode == '0, "R6 waits at zero", dacCode, 0);
    vidCode = 8'd4;
    vidValid = 1'b1;
    tick();
    vidValid = 1'b0;
    wait_done(1000, cyc, jump, lowest);
    check(cyc + 1 == 4 * 1 + 1, "R6 VID ramp time", cyc + 1, 5);
    check(dacCode == 8'd4, "R6 VID target", dacCode, 4);

    // R7: command equal to present code gives no pulse
    vidValid = 1'b1;
    tick();
    vidValid = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 10; k++) begin tick(); if (rampDone) seen = 1'b1; end
    check(!seen, "R7 no pulse on same target", seen, 0);

    // R8: redirect down mid-ramp
    start_run(8'd20, 8'd2);
    for (int k = 0; k < 200 && dacCode != 8'd6; k++) tick();
    vidCode = 8'd3;
    vidValid = 1'b1;
    tick();
    vidValid = 1'b0;
    check(dacCode >= 8'd6, "R8 code kept on redirect", dacCode, 6);
    wait_done(1000, cyc, jump, lowest);
    check(dacCode == 8'd3, "R8 redirect target", dacCode, 3);
    check(lowest >= 3, "R8 no restart from zero", lowest, 3);

    // R8: redirect coinciding with the step that lands on the old target
    start_run(8'd4, 8'd1);
    for (int k = 0; k < 20 && dacCode != 8'd3; k++) tick();
    vidCode = 8'd8;
    vidValid = 1'b1;
    tick();
    vidValid = 1'b0;
    check(dacCode == 8'd4, "R8 step during redirect", dacCode, 4);
    check(rampDone == 1'b0, "R8 no pulse on old target", rampDone, 0);
    wait_done(100, cyc, jump, lowest);
    check(cyc == 4, "R8 cycles to new target", cyc, 4);
    check(dacCode == 8'd8 && rampDone, "R8 pulse on new target", dacCode, 8);

    // R9: per-phase release
    pwmRaw = 2'b00;
    tick();
    check(pwmState == ALL_MID, "R9 mid before pulses", pwmState, ALL_MID);
    pwmRaw = 2'b01;
    #1;
    check(pwmState == 4'b1001, "R9 phase0 high on first pulse", pwmState, 4'b1001);
    tick();
    pwmRaw = 2'b00;
    #1;
    check(pwmState == 4'b1000, "R9 phase0 low, phase1 mid", pwmState, 4'b1000);
    pwmRaw = 2'b10;
    #1;
    check(pwmState == 4'b0100, "R9 phase1 high on first pulse", pwmState, 4'b0100);
    tick();
    pwmRaw = 2'b00;
    #1;
    check(pwmState == 4'b0000, "R9 both low after release", pwmState, 4'b0000);

    // R10: disable returns to mid together with a pulse
    enReq = 1'b0;
    pwmRaw = 2'b11;
    tick();
    check(pwmState == ALL_MID, "R10 mid after disable", pwmState, ALL_MID);
    check(drvEnOut == 1'b0, "R10 driver off after disable", drvEnOut, 0);
    tick();
    check(dacCode == '0, "R10 code cleared", dacCode, 0);
    pwmRaw = 2'b00;
    tick();
    pwmRaw = 2'b01;
    #1;
    check(pwmState == ALL_MID, "R10 pulses ignored while disabled", pwmState, ALL_MID);
    pwmRaw = 2'b00;
    tick();

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule